// File: doc/BRIEF.md
# Lane-Splittable 48-bit Adder/Subtractor

This block adds or subtracts two 48-bit operands, and the one datapath can be split at run time into independent lanes. A two-bit mode input picks the split: one 48-bit lane, two 24-bit lanes, or four 12-bit lanes. When the datapath is split, no carry or borrow passes from one lane into the next. Each lane reports its own carry-out at a fixed position in a 4-bit carry vector.

A single select chooses addition or subtraction for all lanes at once. The carry input feeds only the lowest lane. In the higher lanes it has no effect. Sum and carry vector are registered, so a result appears one clock after its operands are presented. Packed small-word arithmetic uses the block in its split modes, and wide accumulation or compare logic uses it in single mode.

Top module: `simd_addsub48`

## Requirements
- R1: While rst_n is low (asynchronous, active low), sum and cout are all zeros.
- R2: sum and cout show the result of the operands, mode, sub and cin sampled at the previous rising clock edge (one cycle of latency).
- R3: With mode 2'b00 and sub=0, sum = op_a + op_b + cin modulo 2^48, and cout[0] is bit 48 of that total.
- R4: With mode 2'b01, bits 23:0 and bits 47:24 are separate lanes. cin enters only the low lane. cout[0] is the carry of the low lane and cout[1] is the carry of the high lane.
- R5: With mode 2'b10 or 2'b11, there are four 12-bit lanes. Lane k covers bits 12k+11:12k, and cout[k] is the carry of lane k (k = 0..3).
- R6: In a split mode, a lane that overflows (for example, an all-ones lane plus one) leaves the sum bits of the next lane above it unchanged.
- R7: With sub=1, every lane computes A minus B on its own bits. The lowest lane also subtracts cin. A lane's carry bit is 1 when that lane produced no borrow, and 0 when it did.
- R8: Carry bits that the mode does not use read zero: cout[3:1] in mode 2'b00, and cout[3:2] in mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 48 | First operand (minuend when subtracting) |
| op_b | input | 48 | Second operand (subtrahend when subtracting) |
| sub | input | 1 | 0 selects addition, 1 selects subtraction |
| cin | input | 1 | Carry into the lowest lane (borrow when subtracting) |
| mode | input | 2 | Lane split: 00 one lane, 01 two lanes, 1x four lanes |
| sum | output | 48 | Registered lane results |
| cout | output | 4 | Registered per-lane carry flags, lowest lane in bit 0 |

## Verification
Random operands in every mode give general coverage of addition and subtraction. Another set of operands forces some lanes to all ones, so that carries are generated at every lane boundary. The expected value of the lane above such a boundary is then different depending on whether the chain is broken there. This separates a correct split from a chain that leaks across the boundary.

Directed subtractions with equal operands and with a smaller minuend separate the no-borrow carry sense from the inverted sense. A nonzero cin in split modes shows whether the carry input reaches only the lowest lane. Mode 2'b11 is tried against mode 2'b10 to confirm that the two give the same four-lane result.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'b00,
    MODE_TWO  = 2'b01,
    MODE_FOUR = 2'b10,
    MODE_FOURB = 2'b11
  } lane_mode_e;

  // number of base slices that form one lane in the given mode
  function automatic int unsigned slices_per_lane(lane_mode_e m, int unsigned slices);
    case (m)
      MODE_ONE: return slices;
      MODE_TWO: return slices / 2;
      default:  return 1;
    endcase
  endfunction

  // a slice heads a lane when it sits on a lane boundary
  function automatic logic slice_is_head(lane_mode_e m, int unsigned idx, int unsigned slices);
    int unsigned g;
    g = slices_per_lane(m, slices);
    return (idx % g) == 0;
  endfunction

endpackage

// File: rtl/simd_lane_slice.sv
module simd_lane_slice #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  always_comb begin
    b_eff = sub ? ~b : b;
    total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, carry_in};
  end

  assign sum       = total[W-1:0];
  assign carry_out = total[W];
endmodule

// File: rtl/simd_cout_pack.sv
module simd_cout_pack
  import simd_add_pkg::*;
#(
  parameter int unsigned SLICES = 4
) (
  input  lane_mode_e        mode,
  input  logic [SLICES-1:0] slice_cout,
  output logic [SLICES-1:0] packed_cout
);
  localparam int unsigned IW = (SLICES > 1) ? $clog2(SLICES) : 1;

  always_comb begin
    int unsigned g;
    g = slices_per_lane(mode, SLICES);
    packed_cout = '0;
    for (int unsigned k = 0; k < SLICES; k++) begin
      if (k < SLICES / g) packed_cout[k] = slice_cout[IW'((k + 1) * g - 1)];
    end
  end
endmodule

// File: rtl/simd_addsub48.sv
module simd_addsub48
  import simd_add_pkg::*;
#(
  parameter int unsigned LANE_W = 12,
  parameter int unsigned LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANE_W*LANES-1:0] op_a,
  input  logic [LANE_W*LANES-1:0] op_b,
  input  logic                    sub,
  input  logic                    cin,
  input  logic [1:0]              mode,
  output logic [LANE_W*LANES-1:0] sum,
  output logic [LANES-1:0]        cout
);
  localparam int unsigned DW = LANE_W * LANES;

  lane_mode_e       mode_e;
  logic [LANES-1:0] lane_cin;
  logic [LANES-1:0] lane_cout;
  logic [DW-1:0]    comb_sum;
  logic [LANES-1:0] comb_cout;

  assign mode_e = lane_mode_e'(mode);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic c_in;
    logic c_out;
    if (i == 0) begin : g_head
      assign c_in = sub ? ~cin : cin;
    end else begin : g_link
      assign c_in = slice_is_head(mode_e, unsigned'(i), LANES) ? sub : g_lane[i-1].c_out;
    end
    simd_lane_slice #(.W(LANE_W)) u_slice (
      .a        (op_a[i*LANE_W +: LANE_W]),
      .b        (op_b[i*LANE_W +: LANE_W]),
      .sub      (sub),
      .carry_in (c_in),
      .sum      (comb_sum[i*LANE_W +: LANE_W]),
      .carry_out(c_out)
    );
    assign lane_cin[i]  = c_in;
    assign lane_cout[i] = c_out;
  end

  simd_cout_pack #(.SLICES(LANES)) u_pack (
    .mode       (mode_e),
    .slice_cout (lane_cout),
    .packed_cout(comb_cout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum  <= '0;
      cout <= '0;
    end else begin
      sum  <= comb_sum;
      cout <= comb_cout;
    end
  end
endmodule

// File: rtl/simd_addsub48_chk.sv
module simd_addsub48_chk #(
  parameter int unsigned LANE_W = 12,
  parameter int unsigned LANES  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANE_W*LANES-1:0] op_a,
  input logic [LANE_W*LANES-1:0] op_b,
  input logic                    sub,
  input logic                    cin,
  input logic [1:0]              mode,
  input logic [LANE_W*LANES-1:0] sum,
  input logic [LANES-1:0]        cout,
  input logic [LANES-1:0]        lane_cin,
  input logic [LANES-1:0]        lane_cout
);
  localparam int unsigned DW = LANE_W * LANES;
  localparam int unsigned H  = DW / 2;

  logic          armed;
  logic [DW-1:0] b_sel;
  logic          c_low;
  logic [DW:0]   exp_one;
  logic [H:0]    exp_lo, exp_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always_comb begin
    b_sel   = sub ? ~op_b : op_b;
    c_low   = sub ? ~cin : cin;
    exp_one = {1'b0, op_a} + {1'b0, b_sel} + {{DW{1'b0}}, c_low};
    exp_lo  = {1'b0, op_a[H-1:0]} + {1'b0, b_sel[H-1:0]} + {{H{1'b0}}, c_low};
    exp_hi  = {1'b0, op_a[DW-1:H]} + {1'b0, b_sel[DW-1:H]} + {{H{1'b0}}, sub};
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (sum == '0 && cout == '0));

  // R3 and R7 (single lane, add and subtract)
  assert_single_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mode) == 2'b00) |-> ({cout[0], sum} == $past(exp_one)));

  assert_dual_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mode) == 2'b01) |->
      ({cout[1:0], sum} == $past({exp_hi[H], exp_lo[H], exp_hi[H-1:0], exp_lo[H-1:0]})));

  assert_quad_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mode[1])) |-> (cout == $past(lane_cout)));

  assert_no_cross_quad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (lane_cin[LANES-1:1] == {(LANES-1){sub}}));

  assert_no_cross_dual_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (lane_cin[LANES/2] == sub));

  assert_unused_cout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(mode) == 2'b00) ? ((cout >> 1) == '0) :
               ($past(mode) == 2'b01) ? ((cout >> 2) == '0) : 1'b1));
endmodule

bind simd_addsub48 simd_addsub48_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_a     (op_a),
  .op_b     (op_b),
  .sub      (sub),
  .cin      (cin),
  .mode     (mode),
  .sum      (sum),
  .cout     (cout),
  .lane_cin (lane_cin),
  .lane_cout(lane_cout)
);

// File: tb/simd_addsub48_test.sv
`timescale 1ns/1ps
module simd_addsub48_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] op_a, op_b;
  logic        sub, cin;
  logic [1:0]  mode;
  logic [47:0] sum;
  logic [3:0]  cout;

  int checks = 0;
  int errors = 0;

  logic [53:0] q_exp[$];   // {mode, cout, sum}
  string       q_tag[$];

  always #2 clk = ~clk;

  simd_addsub48 uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .sub(sub), .cin(cin), .mode(mode), .sum(sum), .cout(cout)
  );

  function automatic logic [51:0] model(input logic [47:0] a, input logic [47:0] b,
                                         input logic s, input logic c, input logic [1:0] m);
    int                nseg;
    int                w;
    longint unsigned   mask, av, bv, ci, r;
    logic [47:0]       rs;
    logic [3:0]        co;
    nseg = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
    w    = 48 / nseg;
    mask = (64'd1 << w) - 64'd1;
    rs   = '0;
    co   = '0;
    for (int k = 0; k < nseg; k++) begin
      av = (64'(a) >> (k * w)) & mask;
      bv = (64'(b) >> (k * w)) & mask;
      if (s) bv = (~bv) & mask;
      if (k == 0) ci = (s ? !c : c) ? 64'd1 : 64'd0;
      else        ci = s ? 64'd1 : 64'd0;
      r = av + bv + ci;
      rs = rs | 48'((r & mask) << (k * w));
      co[k] = 1'((r >> w) & 64'd1);
    end
    return {co, rs};
  endfunction

  task automatic compare_pending();
    logic [53:0] e;
    string       t;
    if (q_exp.size() > 0) begin
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if ({cout, sum} !== e[51:0]) begin
        errors++;
        $display("FAIL %s (R2 latency): got cout=%h sum=%h expected cout=%h sum=%h",
                 t, cout, sum, e[51:48], e[47:0]);
      end
      if (e[53:52] != 2'b10 && e[53:52] != 2'b11) begin
        checks++;
        if ((e[53:52] == 2'b00 && cout[3:1] != 3'b000) ||
            (e[53:52] == 2'b01 && cout[3:2] != 2'b00)) begin
          errors++;
          $display("FAIL R8: unused carry bits got cout=%b expected upper bits zero", cout);
        end
      end
    end
  endtask

  task automatic step(input logic [47:0] a, input logic [47:0] b, input logic s,
                      input logic c, input logic [1:0] m, input string tag);
    @(negedge clk);
    compare_pending();
    op_a = a; op_b = b; sub = s; cin = c; mode = m;
    q_exp.push_back({m, model(a, b, s, c, m)});
    q_tag.push_back(tag);
  endtask

  function automatic logic [47:0] rnd48();
    return 48'({$urandom, $urandom});
  endfunction

  function automatic string rtag(input logic s, input logic [1:0] m);
    if (s) return "R7";
    if (m == 2'b00) return "R3";
    if (m == 2'b01) return "R4";
    return "R5";
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no completion expected end of run");
    finish_run();
  end

  initial begin
    logic [47:0] a;
    logic [47:0] lanes_ones;
    rst_n = 1'b0;
    op_a = 48'hFFFF_FFFF_FFFF; op_b = 48'h1; sub = 1'b0; cin = 1'b1; mode = 2'b10;
    repeat (3) @(negedge clk);
    checks++;
    if (sum !== 48'h0 || cout !== 4'h0) begin
      errors++;
      $display("FAIL R1: got cout=%h sum=%h expected 0 0", cout, sum);
    end
    rst_n = 1'b1;

    // single lane carry out
    step(48'hFFFF_FFFF_FFFF, 48'h1, 1'b0, 1'b0, 2'b00, "R3");
    step(48'hFFFF_FFFF_FFFF, 48'h0, 1'b0, 1'b1, 2'b00, "R3");
    // boundary isolation
    step(48'h000000_FFFFFF, 48'h000000_000001, 1'b0, 1'b0, 2'b01, "R6");
    step(48'h000_FFF_000_FFF, 48'h000_001_000_001, 1'b0, 1'b0, 2'b10, "R6");
    step(48'hFFF_FFF_FFF_FFF, 48'h001_001_001_001, 1'b0, 1'b0, 2'b10, "R6");
    step(48'hFFF_FFF_FFF_FFF, 48'h001_001_001_001, 1'b0, 1'b0, 2'b00, "R3");
    // cin only into the lowest lane
    step(48'h0, 48'h0, 1'b0, 1'b1, 2'b01, "R4");
    step(48'h0, 48'h0, 1'b0, 1'b1, 2'b10, "R5");
    step(48'h000_000_000_FFF, 48'h0, 1'b0, 1'b1, 2'b11, "R5");
    // subtraction borrow sense
    step(48'h5, 48'h7, 1'b1, 1'b0, 2'b00, "R7");
    step(48'h7, 48'h7, 1'b1, 1'b0, 2'b00, "R7");
    step(48'h7, 48'h7, 1'b1, 1'b1, 2'b00, "R7");
    step(48'h0, 48'h001_000_001_000, 1'b1, 1'b0, 2'b10, "R7");
    step(48'h000001_000000, 48'h000000_000001, 1'b1, 1'b0, 2'b01, "R7");
    step(48'h0, 48'h0, 1'b1, 1'b1, 2'b11, "R7");

    // random operands in every mode, plain and with forced all-ones lanes
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 300; n++) begin
        logic s;
        s = 1'($urandom);
        a = rnd48();
        if (n % 2 == 1) begin
          lanes_ones = '0;
          for (int k = 0; k < 4; k++) if ($urandom % 2 == 1) lanes_ones[k*12 +: 12] = 12'hFFF;
          a = a | lanes_ones;
        end
        step(a, (n % 3 == 0) ? 48'h001_001_001_001 : rnd48(), s, 1'($urandom), 2'(m),
             (n % 2 == 1) ? "R6" : rtag(s, 2'(m)));
      end
    end

    @(negedge clk);
    compare_pending();
    finish_run();
  end
endmodule